// File: doc/BRIEF.md
# Dual-Standard Interlaced Sync Timing Generator

This block derives every timing signal for one interlaced composite video channel from a single 27 MHz system clock. It counts pixels within a line and lines within a frame, and decodes those counts into active-low horizontal and vertical sync, an odd/even field flag and an active-picture flag. An overlay renderer reads characters from its display memory with these outputs. One select input picks either the 525-line standard (1716 clocks per line) or the 625-line standard (1728 clocks per line). A change to that select is held back until the next frame begins, so a frame never mixes the two standards.

In internal mode the counters run free and the separated sync inputs have no effect. In external mode a falling edge on the separated horizontal sync restarts the pixel count. A falling edge on the separated vertical sync reloads the line count. Its position within the current line sets the field it marks. The pixel count keeps running through a vertical reload, so the half-line offset between the two fields is kept.

A lock state machine has three states. FREE is used in internal mode. TRACK is used in external mode while horizontal sync keeps arriving. LOST is used in external mode after horizontal sync has stayed away too long. It has these transitions:
- FREE to TRACK when external mode is selected.
- TRACK or LOST back to FREE when internal mode is selected.
- TRACK to LOST when a line ends on its own count and that line is the fifth in a row without an input horizontal sync edge.
- LOST to TRACK on the next input horizontal sync edge.

In LOST the counters keep running free and the loss-of-lock output is high.

Top module: `vsg_top`

## Requirements
- R1: While reset is high and in the first cycle after it, the pixel count and line count are 0, hsync_n and vsync_n are low, field_o is 0 (first field), lock_lost_o is 0, and the standard is taken from std_pal.
- R2: With no realignment, the pixel count rises by one per clock and wraps to 0 after the last clock of the line. The last clock is LINE_CLKS-1, where LINE_CLKS is 1716 for std_pal=0 and 1728 for std_pal=1. The line count rises by one at each wrap and returns to 0 after line FRAME_LINES-1, where FRAME_LINES is 525 or 625.
- R3: hsync_n is low exactly while the pixel count is below HSYNC_CLKS (127 by default).
- R4: The first field's vertical sync is low for line counts 0 to VSYNC_LINES-1 over whole lines. The second field's vertical sync starts at line F1S = (FRAME_LINES-1)/2, pixel LINE_CLKS/2, and ends at the same pixel VSYNC_LINES lines later. Its start is therefore half a line offset from the first field's.
- R5: field_o is 1 (second field) from line F1S, pixel LINE_CLKS/2, to the end of the frame, and 0 otherwise.
- R6: active_o is high when the pixel count lies in [H_ACT_START, H_ACT_START+H_ACT_LEN) and the line count lies in the field's active band. The first field's band is [V_BLANK, F1S). The second field's band is [F1S+1+V_BLANK, FRAME_LINES).
- R7: The line and frame lengths change to a new std_pal value only at the clock where the counters return to pixel 0, line 0.
- R8: In internal mode (ext_sync=0), edges on ext_hs_n and ext_vs_n have no effect on the counters.
- R9: In external mode, once the lock state is TRACK or LOST, a falling edge on ext_hs_n makes the pixel count read 0 on the next clock. The line count then advances as if the line had ended.
- R10: In that same condition, a falling edge on ext_vs_n loads the line count without changing the pixel count. The value is 0 when the pixel count is below LINE_CLKS/2 or when a horizontal sync edge falls in the same clock, and F1S otherwise.
- R11: In external mode, if five line ends in a row (MISS_LIMIT+1, with MISS_LIMIT=4) arrive with no input horizontal sync edge, lock_lost_o rises on the next clock and the counters keep running free.
- R12: In LOST, the next falling edge on ext_hs_n clears lock_lost_o and realigns the pixel count. Selecting internal mode also clears lock_lost_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz system clock |
| rst | input | 1 | Synchronous reset, active high |
| std_pal | input | 1 | Standard select: 0 = 525-line, 1 = 625-line |
| ext_sync | input | 1 | Sync mode: 0 = internal free-run, 1 = external lock |
| ext_hs_n | input | 1 | Separated horizontal sync from the input video, active low |
| ext_vs_n | input | 1 | Separated vertical sync from the input video, active low |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| field_o | output | 1 | Field flag: 0 = first field, 1 = second field |
| active_o | output | 1 | Active picture flag |
| pix_o | output | PIX_W (11) | Pixel count within the line |
| line_o | output | LINE_W (10) | Line count within the frame |
| lock_lost_o | output | 1 | Loss-of-lock flag in external mode |

## Verification
The bench builds the block with a 20-clock, 7-line small standard and a 24-clock, 9-line large standard. It uses a 3-clock horizontal sync, one vertical sync line, a 10-clock active window starting at pixel 5, and two blanking lines per field. At these sizes every pixel and line of several whole frames in both standards can be compared with an arithmetic reference on every clock. That covers both half-line vertical sync placements, the field boundary and the mid-frame standard change. The loss limit keeps its default of four lines, so the five-line timeout, the relock and the vertical reload on either side of mid-line all occur within a few hundred clocks.

// File: rtl/vsg_pkg.sv
package vsg_pkg;

    typedef enum logic [1:0] {
        LK_FREE  = 2'd0,
        LK_TRACK = 2'd1,
        LK_LOST  = 2'd2
    } lock_state_e;

endpackage

// File: rtl/vsg_lock_fsm.sv
module vsg_lock_fsm
    import vsg_pkg::*;
#(
    parameter int MISS_LIMIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic ext_mode,
    input  logic hs_fall,
    input  logic line_end,
    output logic sync_ok,
    output logic lock_lost
);

    localparam int MW = $clog2(MISS_LIMIT + 1);
    localparam logic [MW-1:0] MISS_MAX = MW'(MISS_LIMIT);

    lock_state_e    state, state_nx;
    logic [MW-1:0]  miss, miss_nx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= LK_FREE;
            miss  <= '0;
        end else begin
            state <= state_nx;
            miss  <= miss_nx;
        end
    end

    always_comb begin
        state_nx = state;
        miss_nx  = miss;
        unique case (state)
            LK_FREE: begin
                miss_nx = '0;
                if (ext_mode) state_nx = LK_TRACK;
            end
            LK_TRACK: begin
                if (!ext_mode) begin
                    state_nx = LK_FREE;
                    miss_nx  = '0;
                end else if (hs_fall) begin
                    miss_nx = '0;
                end else if (line_end) begin
                    if (miss == MISS_MAX) begin
                        state_nx = LK_LOST;
                        miss_nx  = '0;
                    end else begin
                        miss_nx = miss + 1'b1;
                    end
                end
            end
            LK_LOST: begin
                if (!ext_mode) begin
                    state_nx = LK_FREE;
                    miss_nx  = '0;
                end else if (hs_fall) begin
                    state_nx = LK_TRACK;
                    miss_nx  = '0;
                end
            end
            default: begin
                state_nx = LK_FREE;
                miss_nx  = '0;
            end
        endcase
    end

    always_comb begin
        sync_ok   = ext_mode && (state != LK_FREE);
        lock_lost = (state == LK_LOST);
    end

    // R11
    lol_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_lost) |-> ($past(ext_mode) && $past(line_end) && !$past(hs_fall)));

    // R12
    lol_exit_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(lock_lost) |-> ($past(hs_fall) || !$past(ext_mode)));

    // R11
    miss_bound_chk: assert property (@(posedge clk) disable iff (rst)
        miss <= MISS_MAX);

endmodule

// File: rtl/vsg_hcount.sv
module vsg_hcount #(
    parameter int PIX_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PIX_W-1:0] line_len,
    input  logic             realign,
    output logic [PIX_W-1:0] pix,
    output logic             line_end,
    output logic             restart
);

    always_comb begin
        line_end = (pix >= line_len - 1'b1);
        restart  = realign || line_end;
    end

    always_ff @(posedge clk) begin
        if (rst)          pix <= '0;
        else if (restart) pix <= '0;
        else              pix <= pix + 1'b1;
    end

    // R2
    pix_range_chk: assert property (@(posedge clk) disable iff (rst)
        pix < line_len);

    // R9
    realign_zero_chk: assert property (@(posedge clk) disable iff (rst)
        realign |=> (pix == '0));

endmodule

// File: rtl/vsg_vcount.sv
module vsg_vcount #(
    parameter int PIX_W    = 11,
    parameter int LINE_W   = 10,
    parameter int SMALL_L  = 1716,
    parameter int SMALL_N  = 525,
    parameter int LARGE_L  = 1728,
    parameter int LARGE_N  = 625
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              std_pal,
    input  logic [PIX_W-1:0]  pix,
    input  logic              restart,
    input  logic              hs_realign,
    input  logic              vs_realign,
    output logic [LINE_W-1:0] line_q,
    output logic [PIX_W-1:0]  line_len,
    output logic [LINE_W-1:0] frame_lines
);

    localparam logic [PIX_W-1:0]  S_LEN = PIX_W'(SMALL_L);
    localparam logic [PIX_W-1:0]  L_LEN = PIX_W'(LARGE_L);
    localparam logic [LINE_W-1:0] S_NUM = LINE_W'(SMALL_N);
    localparam logic [LINE_W-1:0] L_NUM = LINE_W'(LARGE_N);

    logic              std_q;
    logic [PIX_W-1:0]  half;
    logic [LINE_W-1:0] f1s;
    logic [LINE_W-1:0] line_nx;
    logic              new_frame;

    always_comb begin
        line_len    = std_q ? L_LEN : S_LEN;
        frame_lines = std_q ? L_NUM : S_NUM;
        half        = line_len >> 1;
        f1s         = (frame_lines - 1'b1) >> 1;

        line_nx = line_q;
        if (restart)
            line_nx = (line_q >= frame_lines - 1'b1) ? '0 : line_q + 1'b1;
        if (vs_realign) begin
            if (hs_realign || (pix < half)) line_nx = '0;
            else                            line_nx = f1s;
        end
        new_frame = restart && (line_nx == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= '0;
            std_q  <= std_pal;
        end else begin
            line_q <= line_nx;
            if (new_frame) std_q <= std_pal;
        end
    end

    // R7
    std_frame_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(std_q) |-> ((line_q == '0) && (pix == '0)));

    // R10
    vs_place_chk: assert property (@(posedge clk) disable iff (rst)
        (vs_realign && !hs_realign) |=> ((line_q == '0) || (line_q == $past(f1s))));

endmodule

// File: rtl/vsg_decode.sv
module vsg_decode #(
    parameter int PIX_W       = 11,
    parameter int LINE_W      = 10,
    parameter int HSYNC_CLKS  = 127,
    parameter int VSYNC_LINES = 3,
    parameter int H_ACT_START = 256,
    parameter int H_ACT_LEN   = 1440,
    parameter int V_BLANK     = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PIX_W-1:0]  pix,
    input  logic [LINE_W-1:0] line_q,
    input  logic [PIX_W-1:0]  line_len,
    input  logic [LINE_W-1:0] frame_lines,
    output logic              hsync_n,
    output logic              vsync_n,
    output logic              field,
    output logic              active
);

    localparam logic [PIX_W-1:0]  HS_W  = PIX_W'(HSYNC_CLKS);
    localparam logic [PIX_W-1:0]  HA_LO = PIX_W'(H_ACT_START);
    localparam logic [PIX_W-1:0]  HA_HI = PIX_W'(H_ACT_START + H_ACT_LEN);
    localparam logic [LINE_W-1:0] VS_N  = LINE_W'(VSYNC_LINES);
    localparam logic [LINE_W-1:0] VB_N  = LINE_W'(V_BLANK);

    logic [PIX_W-1:0]  half;
    logic [LINE_W-1:0] f1s;
    logic              vs_first, vs_second, act_h, act_v;

    always_comb begin
        half  = line_len >> 1;
        f1s   = (frame_lines - 1'b1) >> 1;
        field = (line_q > f1s) || ((line_q == f1s) && (pix >= half));

        vs_first  = (line_q < VS_N);
        vs_second = ((line_q == f1s) && (pix >= half))
                 || ((line_q > f1s) && (line_q < f1s + VS_N))
                 || ((line_q == f1s + VS_N) && (pix < half));

        hsync_n = !(pix < HS_W);
        vsync_n = !(vs_first || vs_second);

        act_h = (pix >= HA_LO) && (pix < HA_HI);
        act_v = field ? (line_q >= f1s + 1'b1 + VB_N)
                      : ((line_q >= VB_N) && (line_q < f1s));
        active = act_h && act_v;
    end

    // R3
    hs_start_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(hsync_n) |-> (pix == '0));

    // R4
    field_vs_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(field) |-> !vsync_n);

    // R6
    active_sync_chk: assert property (@(posedge clk) disable iff (rst)
        active |-> (hsync_n && vsync_n));

endmodule

// File: rtl/vsg_top.sv
module vsg_top #(
    parameter int NTSC_LINE_CLKS   = 1716,
    parameter int NTSC_FRAME_LINES = 525,
    parameter int PAL_LINE_CLKS    = 1728,
    parameter int PAL_FRAME_LINES  = 625,
    parameter int HSYNC_CLKS       = 127,
    parameter int VSYNC_LINES      = 3,
    parameter int H_ACT_START      = 256,
    parameter int H_ACT_LEN        = 1440,
    parameter int V_BLANK          = 20,
    parameter int MISS_LIMIT       = 4,
    localparam int MAX_L  = (NTSC_LINE_CLKS > PAL_LINE_CLKS) ? NTSC_LINE_CLKS : PAL_LINE_CLKS,
    localparam int MAX_N  = (NTSC_FRAME_LINES > PAL_FRAME_LINES) ? NTSC_FRAME_LINES : PAL_FRAME_LINES,
    localparam int PIX_W  = $clog2(MAX_L + 1),
    localparam int LINE_W = $clog2(MAX_N + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              std_pal,
    input  logic              ext_sync,
    input  logic              ext_hs_n,
    input  logic              ext_vs_n,
    output logic              hsync_n,
    output logic              vsync_n,
    output logic              field_o,
    output logic              active_o,
    output logic [PIX_W-1:0]  pix_o,
    output logic [LINE_W-1:0] line_o,
    output logic              lock_lost_o
);

    logic              hs_prev, vs_prev;
    logic              hs_fall, vs_fall;
    logic              sync_ok;
    logic              hs_realign, vs_realign;
    logic              line_end, restart;
    logic [PIX_W-1:0]  line_len;
    logic [LINE_W-1:0] frame_lines;

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_prev <= 1'b1;
            vs_prev <= 1'b1;
        end else begin
            hs_prev <= ext_hs_n;
            vs_prev <= ext_vs_n;
        end
    end

    always_comb begin
        hs_fall    = hs_prev && !ext_hs_n;
        vs_fall    = vs_prev && !ext_vs_n;
        hs_realign = sync_ok && hs_fall;
        vs_realign = sync_ok && vs_fall;
    end

    vsg_lock_fsm #(.MISS_LIMIT(MISS_LIMIT)) u_lock (
        .clk       (clk),
        .rst       (rst),
        .ext_mode  (ext_sync),
        .hs_fall   (hs_fall),
        .line_end  (line_end),
        .sync_ok   (sync_ok),
        .lock_lost (lock_lost_o)
    );

    vsg_hcount #(.PIX_W(PIX_W)) u_h (
        .clk      (clk),
        .rst      (rst),
        .line_len (line_len),
        .realign  (hs_realign),
        .pix      (pix_o),
        .line_end (line_end),
        .restart  (restart)
    );

    vsg_vcount #(
        .PIX_W   (PIX_W),
        .LINE_W  (LINE_W),
        .SMALL_L (NTSC_LINE_CLKS),
        .SMALL_N (NTSC_FRAME_LINES),
        .LARGE_L (PAL_LINE_CLKS),
        .LARGE_N (PAL_FRAME_LINES)
    ) u_v (
        .clk         (clk),
        .rst         (rst),
        .std_pal     (std_pal),
        .pix         (pix_o),
        .restart     (restart),
        .hs_realign  (hs_realign),
        .vs_realign  (vs_realign),
        .line_q      (line_o),
        .line_len    (line_len),
        .frame_lines (frame_lines)
    );

    vsg_decode #(
        .PIX_W       (PIX_W),
        .LINE_W      (LINE_W),
        .HSYNC_CLKS  (HSYNC_CLKS),
        .VSYNC_LINES (VSYNC_LINES),
        .H_ACT_START (H_ACT_START),
        .H_ACT_LEN   (H_ACT_LEN),
        .V_BLANK     (V_BLANK)
    ) u_dec (
        .clk         (clk),
        .rst         (rst),
        .pix         (pix_o),
        .line_q      (line_o),
        .line_len    (line_len),
        .frame_lines (frame_lines),
        .hsync_n     (hsync_n),
        .vsync_n     (vsync_n),
        .field       (field_o),
        .active      (active_o)
    );

    // R8
    internal_free_chk: assert property (@(posedge clk) disable iff (rst)
        (!ext_sync && !line_end && !$past(ext_sync)) |=> (pix_o == $past(pix_o) + 1'b1));

endmodule

// File: tb/tb_vsg_top.sv
module tb_vsg_top;

    localparam int SL = 20, SN = 7, LL = 24, LN = 9;
    localparam int HS = 3, VS = 1, HAS = 5, HAL = 10, VB = 2, ML = 4;
    localparam int PW = $clog2(LL + 1);
    localparam int LW = $clog2(LN + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic std_pal = 1'b0, ext_sync = 1'b0, ext_hs_n = 1'b1, ext_vs_n = 1'b1;
    logic hsync_n, vsync_n, field_o, active_o, lock_lost_o;
    logic [PW-1:0] pix_o;
    logic [LW-1:0] line_o;

    int checks = 0, errors = 0;
    int mpix = 0, mline = 0, mstate = 0, mmiss = 0, k = 0;
    logic mstd = 1'b0, mhsp = 1'b1, mvsp = 1'b1;
    string phase = "init";

    always #4 clk = ~clk;

    vsg_top #(
        .NTSC_LINE_CLKS(SL), .NTSC_FRAME_LINES(SN),
        .PAL_LINE_CLKS(LL),  .PAL_FRAME_LINES(LN),
        .HSYNC_CLKS(HS), .VSYNC_LINES(VS),
        .H_ACT_START(HAS), .H_ACT_LEN(HAL), .V_BLANK(VB), .MISS_LIMIT(ML)
    ) dut (
        .clk(clk), .rst(rst), .std_pal(std_pal), .ext_sync(ext_sync),
        .ext_hs_n(ext_hs_n), .ext_vs_n(ext_vs_n),
        .hsync_n(hsync_n), .vsync_n(vsync_n), .field_o(field_o),
        .active_o(active_o), .pix_o(pix_o), .line_o(line_o),
        .lock_lost_o(lock_lost_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s [%s] k=%0d actual=%0d expected=%0d", req, phase, k, act, exp);
        end
    endtask

    task automatic compare();
        int L, N, h, f, ef, evs, ea;
        L = mstd ? LL : SL;  N = mstd ? LN : SN;
        h = L / 2;           f = (N - 1) / 2;
        ef  = (mline > f || (mline == f && mpix >= h)) ? 1 : 0;
        evs = ((mline < VS) || (mline == f && mpix >= h) ||
               (mline > f && mline < f + VS) || (mline == f + VS && mpix < h)) ? 0 : 1;
        ea  = (mpix >= HAS && mpix < HAS + HAL &&
               (ef == 1 ? (mline >= f + 1 + VB) : (mline >= VB && mline < f))) ? 1 : 0;
        chk(pix_o == PW'(mpix), "R2 pixel", int'(pix_o), mpix);
        chk(line_o == LW'(mline), "R2 line", int'(line_o), mline);
        chk(hsync_n == (mpix >= HS), "R3 hsync", int'(hsync_n), int'(mpix >= HS));
        chk(vsync_n == evs[0], "R4 vsync", int'(vsync_n), evs);
        chk(field_o == ef[0], "R5 field", int'(field_o), ef);
        chk(active_o == ea[0], "R6 active", int'(active_o), ea);
        chk(lock_lost_o == (mstate == 2), "R11 lock_lost", int'(lock_lost_o), int'(mstate == 2));
    endtask

    task automatic cycle(input logic hs, input logic vs);
        int L, N, h, f, npix, nline;
        bit hsf, vsf, sok, nat, rs;
        ext_hs_n = hs; ext_vs_n = vs;
        L = mstd ? LL : SL;  N = mstd ? LN : SN;
        h = L / 2;           f = (N - 1) / 2;
        hsf = mhsp && !hs;   vsf = mvsp && !vs;
        sok = ext_sync && (mstate != 0);
        nat = (mpix == L - 1);
        rs  = (sok && hsf) || nat;
        npix  = rs ? 0 : mpix + 1;
        nline = mline;
        if (rs) nline = (mline >= N - 1) ? 0 : mline + 1;
        if (sok && vsf) nline = ((sok && hsf) || mpix < h) ? 0 : f;
        if (rs && nline == 0) mstd = std_pal;
        case (mstate)
            0: begin mmiss = 0; if (ext_sync) mstate = 1; end
            1: begin
                if (!ext_sync) begin mstate = 0; mmiss = 0; end
                else if (hsf) mmiss = 0;
                else if (nat) begin
                    if (mmiss == ML) begin mstate = 2; mmiss = 0; end
                    else mmiss++;
                end
            end
            default: begin
                if (!ext_sync) begin mstate = 0; mmiss = 0; end
                else if (hsf) begin mstate = 1; mmiss = 0; end
            end
        endcase
        mpix = npix; mline = nline; mhsp = hs; mvsp = vs;
        @(negedge clk);
        k++;
        compare();
    endtask

    initial begin
        #(8 * 150000);
        checks++; errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", k, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int pb;
        repeat (3) @(negedge clk);
        chk(pix_o == 0 && line_o == 0, "R1 counters in reset", int'(pix_o), 0);
        rst = 1'b0;
        mstd = std_pal;
        phase = "R1 reset";
        chk(pix_o == 0 && line_o == 0, "R1 counters", int'(line_o), 0);
        chk(!hsync_n && !vsync_n, "R1 syncs low", int'({hsync_n, vsync_n}), 0);
        chk(!field_o && !lock_lost_o, "R1 field/lock", int'({field_o, lock_lost_o}), 0);
        compare();

        // R7: standard flips mid-frame, applies at frame start
        phase = "R7 free run";
        for (int i = 0; i < 50; i++) cycle(1'b1, 1'b1);
        std_pal = 1'b1;
        for (int i = 50; i < 120; i++) cycle(1'b1, 1'b1);
        chk(line_o == 6 && pix_o == 0, "R7 old length kept", int'(line_o), 6);
        for (int i = 120; i < 163; i++) cycle(1'b1, 1'b1);
        chk(line_o == 0 && pix_o == 23, "R7 new length", int'(pix_o), 23);
        for (int i = 0; i < 2 * LL * LN; i++) cycle(1'b1, 1'b1);

        // R8: internal mode ignores input sync edges
        phase = "R8 internal";
        for (int i = 0; i < 150; i++) begin
            pb = int'(pix_o);
            cycle((i % 7) < 2 ? 1'b0 : 1'b1, (i % 31) == 3 ? 1'b0 : 1'b1);
            if ((i % 7) == 0 && pb != LL - 1)
                chk(int'(pix_o) == pb + 1, "R8 hs ignored", int'(pix_o), pb + 1);
        end

        // R9 / R10: external lock
        phase = "R9 external";
        ext_sync = 1'b1;
        for (int i = 0; i < 4; i++) cycle(1'b1, 1'b1);
        for (int i = 0; i < 6 * LL; i++) begin
            cycle((i % LL) == 7 || (i % LL) == 8 ? 1'b0 : 1'b1, 1'b1);
            if ((i % LL) == 7) chk(pix_o == 0, "R9 hs realign", int'(pix_o), 0);
        end
        phase = "R10 vertical";
        while (mpix != 5) cycle((mpix == 0) ? 1'b0 : 1'b1, 1'b1);
        cycle(1'b1, 1'b0);
        chk(line_o == 0 && pix_o == 6, "R10 early vs to line 0", int'(line_o), 0);
        for (int i = 0; i < 2 * LL; i++) cycle((mpix == LL - 1) ? 1'b0 : 1'b1, 1'b1);
        while (mpix != 15) cycle(1'b1, 1'b1);
        cycle(1'b1, 1'b0);
        chk(line_o == (LN - 1) / 2 && pix_o == 16, "R10 late vs to F1S", int'(line_o), (LN - 1) / 2);
        for (int i = 0; i < 3 * LL; i++) cycle(1'b1, 1'b1);

        // R11: loss of lock after five silent lines
        phase = "R11 loss";
        cycle(1'b0, 1'b1);
        for (int i = 0; i < 4 * LL + 10; i++) cycle(1'b1, 1'b1);
        chk(!lock_lost_o, "R11 not yet lost", int'(lock_lost_o), 0);
        for (int i = 0; i < 2 * LL; i++) cycle(1'b1, 1'b1);
        chk(lock_lost_o, "R11 lost", int'(lock_lost_o), 1);

        // R12: relock
        phase = "R12 relock";
        while (mpix != 9) cycle(1'b1, 1'b1);
        cycle(1'b0, 1'b1);
        chk(!lock_lost_o && pix_o == 0, "R12 relock clears flag", int'(lock_lost_o), 0);
        for (int i = 0; i < LL; i++) cycle(1'b1, 1'b1);

        // back to internal, small standard, two full frames
        phase = "R4 small std";
        ext_sync = 1'b0;
        std_pal = 1'b0;
        for (int i = 0; i < LL * LN + 2 * SL * SN + 40; i++) cycle(1'b1, 1'b1);
        chk(line_o < SN, "R7 small std active", int'(line_o), SN - 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule